// File: doc/BRIEF.md
# Dual-Tone Sample Generator

This block produces a digital dual-tone signalling stream, the kind used for telephone keypad tones. It holds two frequency codes, one for the low-frequency group tone and one for the high-frequency group tone. Each code is written on its own and is used as the step of a phase accumulator. Each time the sample-rate strobe pulses, both accumulators advance. The top bits of each phase select an entry of a quarter-wave sine table.

The two tones have different peak amplitudes. The low tone peaks at ±31 as a 6-bit signed value. The high tone peaks at ±39 as a 7-bit signed value, which puts it close to 2 dB above the low tone. Each narrow sample is widened into a 16-bit linear PCM word by appending seven zero bits. The two widened samples are then added together.

The sum is offered on several output lanes. Each lane has its own enable, and a disabled lane carries zeros. All lanes are registered, so a lane changes only on a sample strobe. Downstream converters, gain stages and the register bus that feeds the write port sit outside the block.

Top module: `dtmf_tone_gen`

## Requirements
- R1: A write with `wr_en`=1 stores `wr_data` as the low-group code when `wr_sel`=0, and as the high-group code when `wr_sel`=1. The other code is left unchanged.
- R2: On every cycle with `sample_stb`=1, each tone's 16-bit phase advances by its code, modulo 2^16. The table index is phase bits [15:10]. The first strobe after a code becomes nonzero uses phase 0.
- R3: The low-group sample for index n is round(31·sin(2πn/64)). It lies within [-32, 31].
- R4: The high-group sample for index n is round(39·sin(2πn/64)). It lies within [-40, 39].
- R5: The mixed word is (low + high)·128 as a 16-bit two's-complement value. Its seven LSBs are always zero and its magnitude never exceeds 70·128.
- R6: While a code is zero, that tone contributes 0 and its phase is held at 0. When a nonzero code is written again, that tone restarts from phase 0.
- R7: On a strobe, lane i of `pcm_out` (bits [16i+15:16i]) loads the mixed word if `port_en[i]`=1. It loads zero if `port_en[i]`=0.
- R8: Lanes change only in the cycle after a strobe. A change of `port_en` between strobes has no effect on any lane.
- R9: A synchronous reset clears both codes, both phases and all lanes to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Code write strobe |
| wr_sel | input | 1 | Write target: 0 selects the low group, 1 selects the high group |
| wr_data | input | 16 | Phase increment code |
| sample_stb | input | 1 | Sample-rate strobe |
| port_en | input | 4 | Per-lane enable, sampled on a strobe |
| pcm_out | output | 64 | Four 16-bit signed PCM lanes, lane i at bits [16i+15:16i] |

## Verification
Some properties are checked on every cycle. Lanes hold still between strobes. A lane disabled at a strobe reads zero afterwards. Every lane keeps seven zero LSBs and stays within the combined peak. Reset empties all lanes. Other behaviours need the bench's scenarios, because only a reference computed from sine values and modelled phases can show them: the exact table values, the phase stepping and wrap, the silencing and restart of a zero code, and the independence of the two code registers.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

    localparam int PHASE_W   = 16;
    localparam int IDX_W     = 6;
    localparam int LO_W      = 6;
    localparam int HI_W      = 7;
    localparam int PCM_W     = 16;
    localparam int PAD_LSB   = 7;
    localparam int LO_PEAK   = 31;
    localparam int HI_PEAK   = 39;
    localparam int QTR_W     = IDX_W - 1;

    // quarter-wave magnitude, k = 0..16 covers 0..pi/2 in steps of pi/32
    function automatic logic [5:0] lo_quarter(input logic [QTR_W-1:0] k);
        case (k)
            5'd0:  lo_quarter = 6'd0;
            5'd1:  lo_quarter = 6'd3;
            5'd2:  lo_quarter = 6'd6;
            5'd3:  lo_quarter = 6'd9;
            5'd4:  lo_quarter = 6'd12;
            5'd5:  lo_quarter = 6'd15;
            5'd6:  lo_quarter = 6'd17;
            5'd7:  lo_quarter = 6'd20;
            5'd8:  lo_quarter = 6'd22;
            5'd9:  lo_quarter = 6'd24;
            5'd10: lo_quarter = 6'd26;
            5'd11: lo_quarter = 6'd27;
            5'd12: lo_quarter = 6'd29;
            5'd13: lo_quarter = 6'd30;
            5'd14: lo_quarter = 6'd30;
            5'd15: lo_quarter = 6'd31;
            5'd16: lo_quarter = 6'd31;
            default: lo_quarter = 6'd0;
        endcase
    endfunction

    function automatic logic [5:0] hi_quarter(input logic [QTR_W-1:0] k);
        case (k)
            5'd0:  hi_quarter = 6'd0;
            5'd1:  hi_quarter = 6'd4;
            5'd2:  hi_quarter = 6'd8;
            5'd3:  hi_quarter = 6'd11;
            5'd4:  hi_quarter = 6'd15;
            5'd5:  hi_quarter = 6'd18;
            5'd6:  hi_quarter = 6'd22;
            5'd7:  hi_quarter = 6'd25;
            5'd8:  hi_quarter = 6'd28;
            5'd9:  hi_quarter = 6'd30;
            5'd10: hi_quarter = 6'd32;
            5'd11: hi_quarter = 6'd34;
            5'd12: hi_quarter = 6'd36;
            5'd13: hi_quarter = 6'd37;
            5'd14: hi_quarter = 6'd38;
            5'd15: hi_quarter = 6'd39;
            5'd16: hi_quarter = 6'd39;
            default: hi_quarter = 6'd0;
        endcase
    endfunction

endpackage

// File: rtl/dtmf_sine_lut.sv
module dtmf_sine_lut
    import dtmf_pkg::*;
#(
    parameter int SAMP_W   = LO_W,
    parameter bit HIGH_GRP = 1'b0
) (
    input  logic [IDX_W-1:0]         idx,
    output logic signed [SAMP_W-1:0] sample
);
    localparam int SUB_W = IDX_W - 2;
    localparam int HALF  = 2 ** SUB_W;

    logic [1:0]       quad;
    logic [SUB_W-1:0] sub;
    logic [QTR_W-1:0] k;
    logic [5:0]       mag;

    assign quad = idx[IDX_W-1 -: 2];
    assign sub  = idx[SUB_W-1:0];

    // mirror on odd quadrants, negate on the second half-wave
    assign k = quad[0] ? QTR_W'(HALF - int'(sub)) : QTR_W'(sub);

    generate
        if (HIGH_GRP) begin : g_high
            assign mag = hi_quarter(k);
        end else begin : g_low
            assign mag = lo_quarter(k);
        end
    endgenerate

    assign sample = quad[1] ? -$signed(SAMP_W'(mag)) : $signed(SAMP_W'(mag));

endmodule

// File: rtl/dtmf_tone_path.sv
module dtmf_tone_path
    import dtmf_pkg::*;
#(
    parameter int PH_W     = PHASE_W,
    parameter int SAMP_W   = LO_W,
    parameter bit HIGH_GRP = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     code_we,
    input  logic [PH_W-1:0]          code_in,
    input  logic                     stb,
    output logic signed [SAMP_W-1:0] sample
);
    typedef struct packed {
        logic [PH_W-1:0] step;
        logic [PH_W-1:0] phase;
    } tone_state_t;

    tone_state_t st_d, st_q;
    logic signed [SAMP_W-1:0] lut_val;
    logic idle;

    assign idle = (st_q.step == '0);

    dtmf_sine_lut #(
        .SAMP_W   (SAMP_W),
        .HIGH_GRP (HIGH_GRP)
    ) u_lut (
        .idx    (st_q.phase[PH_W-1 -: IDX_W]),
        .sample (lut_val)
    );

    assign sample = idle ? '0 : lut_val;

    always_comb begin
        st_d = st_q;
        if (code_we) begin
            st_d.step = code_in;
        end
        if (stb) begin
            st_d.phase = idle ? '0 : st_q.phase + st_q.step;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dtmf_out_stage.sv
module dtmf_out_stage #(
    parameter int N_OUT = 4,
    parameter int PCM_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     stb,
    input  logic [N_OUT-1:0]         lane_en,
    input  logic signed [PCM_W-1:0]  mix,
    output logic [N_OUT*PCM_W-1:0]   lanes
);
    typedef struct packed {
        logic [N_OUT*PCM_W-1:0] lanes;
    } out_state_t;

    out_state_t st_d, st_q;
    logic [N_OUT*PCM_W-1:0] gated;

    generate
        for (genvar i = 0; i < N_OUT; i++) begin : g_lane
            assign gated[i*PCM_W +: PCM_W] = lane_en[i] ? mix : '0;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (stb) begin
            st_d.lanes = gated;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lanes = st_q.lanes;

endmodule

// File: rtl/dtmf_tone_gen.sv
module dtmf_tone_gen
    import dtmf_pkg::*;
#(
    parameter int N_OUT = 4,
    parameter int PH_W  = PHASE_W,
    parameter int OUT_W = PCM_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic                   wr_sel,
    input  logic [PH_W-1:0]        wr_data,
    input  logic                   sample_stb,
    input  logic [N_OUT-1:0]       port_en,
    output logic [N_OUT*OUT_W-1:0] pcm_out
);
    logic signed [LO_W-1:0]  lo_s;
    logic signed [HI_W-1:0]  hi_s;
    logic signed [OUT_W-1:0] lo_wide, hi_wide, mix;

    dtmf_tone_path #(
        .PH_W     (PH_W),
        .SAMP_W   (LO_W),
        .HIGH_GRP (1'b0)
    ) u_low (
        .clk     (clk),
        .rst     (rst),
        .code_we (wr_en & ~wr_sel),
        .code_in (wr_data),
        .stb     (sample_stb),
        .sample  (lo_s)
    );

    dtmf_tone_path #(
        .PH_W     (PH_W),
        .SAMP_W   (HI_W),
        .HIGH_GRP (1'b1)
    ) u_high (
        .clk     (clk),
        .rst     (rst),
        .code_we (wr_en & wr_sel),
        .code_in (wr_data),
        .stb     (sample_stb),
        .sample  (hi_s)
    );

    // widen by sign extension, then append zero LSBs
    assign lo_wide = OUT_W'(lo_s) <<< PAD_LSB;
    assign hi_wide = OUT_W'(hi_s) <<< PAD_LSB;
    assign mix     = lo_wide + hi_wide;

    dtmf_out_stage #(
        .N_OUT (N_OUT),
        .PCM_W (OUT_W)
    ) u_out (
        .clk     (clk),
        .rst     (rst),
        .stb     (sample_stb),
        .lane_en (port_en),
        .mix     (mix),
        .lanes   (pcm_out)
    );

endmodule

// File: rtl/dtmf_tone_gen_chk.sv
module dtmf_tone_gen_chk
    import dtmf_pkg::*;
#(
    parameter int N_OUT = 4,
    parameter int OUT_W = PCM_W
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   sample_stb,
    input logic [N_OUT-1:0]       port_en,
    input logic [N_OUT*OUT_W-1:0] pcm_out
);
    localparam int LIMIT = (LO_PEAK + HI_PEAK) << PAD_LSB;

    // R8: lanes move only after a strobe
    p_hold_between_r8: assert property (@(posedge clk) disable iff (rst)
        !sample_stb |=> $stable(pcm_out));

    // R9: reset empties every lane
    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (pcm_out == '0));

    generate
        for (genvar i = 0; i < N_OUT; i++) begin : g_chk
            // R7: lane disabled at a strobe reads zero
            p_off_lane_zero_r7: assert property (@(posedge clk) disable iff (rst)
                (sample_stb && !port_en[i]) |=> (pcm_out[i*OUT_W +: OUT_W] == '0));
            // R5: padding bits stay zero
            p_pad_zero_r5: assert property (@(posedge clk) disable iff (rst)
                pcm_out[i*OUT_W +: PAD_LSB] == '0);
            // R5: combined peak is never exceeded
            p_peak_r5: assert property (@(posedge clk) disable iff (rst)
                ($signed(pcm_out[i*OUT_W +: OUT_W]) <= LIMIT) &&
                ($signed(pcm_out[i*OUT_W +: OUT_W]) >= -LIMIT));
        end
    endgenerate

endmodule

bind dtmf_tone_gen dtmf_tone_gen_chk #(
    .N_OUT (N_OUT),
    .OUT_W (OUT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sample_stb (sample_stb),
    .port_en    (port_en),
    .pcm_out    (pcm_out)
);

// File: tb/tb_dtmf_tone_gen.sv
module tb_dtmf_tone_gen;
    localparam int N = 4;
    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic           wr_sel = 1'b0;
    logic [15:0]    wr_data = '0;
    logic           sample_stb = 1'b0;
    logic [N-1:0]   port_en = '0;
    logic [N*W-1:0] pcm_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // reference state
    int unsigned m_inc_lo, m_inc_hi, m_ph_lo, m_ph_hi;
    int          m_lane [N];

    always #2 clk = ~clk;

    dtmf_tone_gen dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .sample_stb(sample_stb),
        .port_en(port_en), .pcm_out(pcm_out)
    );

    function automatic int sine_ref(input int amp, input int idx);
        real v;
        v = amp * $sin(2.0 * 3.14159265358979 * idx / 64.0);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_lanes(input string req);
        for (int i = 0; i < N; i++)
            check(req, int'($signed(pcm_out[i*W +: W])), m_lane[i]);
    endtask

    task automatic model_reset();
        m_inc_lo = 0; m_inc_hi = 0; m_ph_lo = 0; m_ph_hi = 0;
        for (int i = 0; i < N; i++) m_lane[i] = 0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cyc(); cyc();
        rst = 1'b0;
        model_reset();
    endtask

    task automatic write_code(input bit sel, input logic [15:0] val);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        cyc();
        wr_en = 1'b0;
        if (sel) m_inc_hi = val; else m_inc_lo = val;
    endtask

    task automatic strobe(input logic [N-1:0] en, input string req);
        int lo, hi, mix;
        port_en = en;
        sample_stb = 1'b1;
        cyc();
        sample_stb = 1'b0;
        if (m_inc_lo == 0) begin lo = 0; m_ph_lo = 0; end
        else begin lo = sine_ref(31, int'(m_ph_lo >> 10)); m_ph_lo = (m_ph_lo + m_inc_lo) & 32'hFFFF; end
        if (m_inc_hi == 0) begin hi = 0; m_ph_hi = 0; end
        else begin hi = sine_ref(39, int'(m_ph_hi >> 10)); m_ph_hi = (m_ph_hi + m_inc_hi) & 32'hFFFF; end
        mix = (lo + hi) * 128;
        for (int i = 0; i < N; i++) m_lane[i] = en[i] ? mix : 0;
        check_lanes(req);
    endtask

    initial begin
        void'($urandom(32'd20240517));
        model_reset();
        do_reset();
        check_lanes("R9 reset state");

        // R3: full low-group sweep, one index per strobe
        write_code(1'b0, 16'h0400);
        for (int s = 0; s < 66; s++) strobe(4'hF, "R3 low table");
        // R6: zeroing silences and restarts at phase 0
        write_code(1'b0, 16'h0000);
        strobe(4'hF, "R6 zero code silent");
        strobe(4'hF, "R6 zero code silent");
        // R4 and R1: high-group sweep, low untouched
        write_code(1'b1, 16'h0400);
        for (int s = 0; s < 66; s++) strobe(4'hF, "R4 high table");
        // R6 restart: low code rewritten, begins from phase 0
        write_code(1'b0, 16'h0C00);
        for (int s = 0; s < 8; s++) strobe(4'hF, "R6 restart R5 mix");
        // R2 wrap: large steps wrap modulo 2^16
        write_code(1'b0, 16'hFC01);
        write_code(1'b1, 16'h8123);
        for (int s = 0; s < 10; s++) strobe(4'hA, "R2 wrap R7 gate");

        // R8: enable changes without strobe are ignored
        port_en = 4'h0;
        cyc(); cyc(); cyc();
        check_lanes("R8 enable ignored between strobes");
        port_en = 4'hF;
        write_code(1'b1, 16'h1234);
        cyc();
        check_lanes("R8 hold across write");

        // random mix
        for (int it = 0; it < 600; it++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op == 0) write_code(1'b0, ($urandom_range(0, 7) == 0) ? 16'h0 : 16'($urandom));
            else if (op == 1) write_code(1'b1, ($urandom_range(0, 7) == 0) ? 16'h0 : 16'($urandom));
            else if (op == 2) begin
                port_en = 4'($urandom);
                cyc();
                check_lanes("R8 random idle");
            end else strobe(4'($urandom), "R2 R5 R7 random");
        end

        // R9: reset mid-run clears state
        write_code(1'b0, 16'h0777);
        write_code(1'b1, 16'h0999);
        strobe(4'hF, "R5 before reset");
        do_reset();
        check_lanes("R9 mid-run reset");
        strobe(4'hF, "R9 codes cleared");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule